// File: doc/BRIEF.md
# Signed/Unsigned Upper-Product Multiplier

This block returns the most significant half of the double-width product of two operands, 64 bits each by default. One mode input sets the signedness of the operands: both signed, the first signed and the second unsigned, or both unsigned. The block takes the magnitude of each operand and multiplies the two magnitudes as four half-width partial products. It adds the middle terms with an explicit carry, then fixes the sign of the upper half. The sign fix uses two's-complement negation, and it adds the increment only when the lower half of the magnitude product is all zeros.

Operands enter through a valid/ready handshake. Each operation passes through three register stages and then waits at the output until it is accepted. When the output is held, the whole pipeline holds. Operations leave in the order they entered, and each accepted input gives exactly one result.

Top module: `mulhi_unit`

## Requirements
- R1: With `in_mode` = 2'b00, both operands are signed two's-complement values, and `out_data` is bits [127:64] of their signed product.
- R2: With `in_mode` = 2'b01, `in_a` is signed and `in_b` is unsigned, and `out_data` is bits [127:64] of their mixed-sign product.
- R3: With `in_mode` = 2'b10 or 2'b11, both operands are unsigned, and `out_data` is bits [127:64] of their unsigned product.
- R4: A signed operand equal to the most negative value (only bit 63 set) is treated as having magnitude 2^63, and the result is correct for it, including when both operands are that value.
- R5: For a negative product, the result is the complement of the magnitude upper half, plus one only when the lower 64 bits of the magnitude product are zero. Example: signed -1 times 1 gives all ones, and signed -2^32 times 2^32 gives all ones.
- R6: With `out_ready` held high, an input accepted at rising edge N gives `out_valid` high with its result after rising edge N+2.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_data` keep their values. Otherwise `in_ready` is high.
- R8: While `rst_n` is low at a rising edge, the pipeline empties. After reset, `out_valid` is low and `in_ready` is high.
- R9: Results appear in acceptance order, one per accepted input, and none appears without an accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_mode | input | 2 | Signedness select (00 ss, 01 su, 10/11 uu) |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Upper half of the product |

## Verification
An accepted operand pair should show its result on `out_valid`/`out_data` after the second rising edge following the capture edge, or later by exactly the number of edges at which the output was held. `in_ready` depends on the current output state and `out_ready`, so it is due in the same cycle. The bench keeps a three-slot model of the pipeline that advances under the same rule at every edge. It compares valid, data and ready once per cycle, on the falling edge, so each check looks at values that settled after the last rising edge. Directed vectors cover the most-negative operands and the low-half-zero negation case. Random traffic with random back-pressure covers all four mode codes.

// File: rtl/mulhi_pkg.sv
// Shared definitions for the upper-product multiplier.
package mulhi_pkg;
    // Signedness selection; code 3 behaves as unsigned by unsigned.
    typedef enum logic [1:0] {
        MODE_SS     = 2'b00,
        MODE_SU     = 2'b01,
        MODE_UU     = 2'b10,
        MODE_UU_ALT = 2'b11
    } mul_mode_e;
endpackage

// File: rtl/mulhi_sign_prep.sv
// Converts operands to unsigned magnitudes and derives the result sign.
// Assumes two's-complement inputs; the most negative value maps to the
// unsigned magnitude 2^(W-1), which fits in W bits.
module mulhi_sign_prep
    import mulhi_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [1:0]   mode,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic a_is_signed, b_is_signed, a_neg, b_neg;

    // Decide which operands are interpreted as signed.
    always_comb begin
        a_is_signed = (mul_mode_e'(mode) == MODE_SS) || (mul_mode_e'(mode) == MODE_SU);
        b_is_signed = (mul_mode_e'(mode) == MODE_SS);
    end

    // Absolute values and sign of the product.
    always_comb begin
        a_neg = a_is_signed & opa[W-1];
        b_neg = b_is_signed & opb[W-1];
        mag_a = a_neg ? (~opa + 1'b1) : opa;
        mag_b = b_neg ? (~opb + 1'b1) : opb;
        neg   = a_neg ^ b_neg;
    end

    // Guard the magnitude corner cases.
    always_comb begin
        if (a_neg && mag_a[W-1]) begin
            a_r4_min_mag_a: assert (opa == MOST_NEG);
        end
        if (b_neg && mag_b[W-1]) begin
            a_r4_min_mag_b: assert (opb == MOST_NEG);
        end
        if (mode[1]) begin
            a_r3_unsigned_no_neg: assert (!neg);
        end
    end
endmodule

// File: rtl/mulhi_part_mul.sv
// Forms the four half-width partial products of two W-bit magnitudes.
// Index bit 1 selects the high half of A, bit 0 the high half of B:
// pp[0]=lo*lo, pp[1]=loA*hiB, pp[2]=hiA*loB, pp[3]=hi*hi.
module mulhi_part_mul #(
    parameter int W = 64
) (
    input  logic [W-1:0]        mag_a,
    input  logic [W-1:0]        mag_b,
    output logic [3:0][W-1:0]   pp
);
    localparam int H = W / 2;

    for (genvar g = 0; g < 4; g++) begin : g_pp
        logic [H-1:0] xa, xb;
        // Pick the halves and multiply them.
        always_comb begin
            xa = g[1] ? mag_a[W-1:H] : mag_a[H-1:0];
            xb = g[0] ? mag_b[W-1:H] : mag_b[H-1:0];
            pp[g] = W'(xa) * W'(xb);
        end
    end
endmodule

// File: rtl/mulhi_combine.sv
// Sums the partial products into the upper half and applies the sign.
// Assumes pp ordering from mulhi_part_mul; the negation increment is
// applied only when the low W bits of the magnitude product are zero.
module mulhi_combine #(
    parameter int W = 64
) (
    input  logic [3:0][W-1:0] pp,
    input  logic              neg,
    output logic [W-1:0]      result
);
    localparam int H = W / 2;

    logic [H+1:0] mid_sum;
    logic [1:0]   carry;
    logic [W-1:0] hi_mag;
    logic         low_zero;

    // Middle column: low halves of the cross terms plus upper half of lo*lo.
    always_comb begin
        mid_sum = {2'b00, pp[1][H-1:0]} + {2'b00, pp[2][H-1:0]} + {2'b00, pp[0][W-1:H]};
        carry   = mid_sum[H+1:H];
    end

    // Magnitude upper half.
    always_comb begin
        hi_mag = pp[3] + (pp[1] >> H) + (pp[2] >> H) + W'(carry);
    end

    // Sign fix-up of the upper half.
    always_comb begin
        low_zero = (pp[0][H-1:0] == '0) && (mid_sum[H-1:0] == '0);
        result   = neg ? (~hi_mag + W'(low_zero)) : hi_mag;
    end
endmodule

// File: rtl/mulhi_unit.sv
// Top of the upper-product multiplier: three register stages
// (capture magnitudes, partial products, combined result) that all
// advance together whenever the output slot is empty or being taken.
module mulhi_unit
    import mulhi_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [1:0]   in_mode,
    input  logic [63:0]  in_a,
    input  logic [63:0]  in_b,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [63:0]  out_data
);
    logic [W-1:0]      c_mag_a, c_mag_b, c_result;
    logic              c_neg;
    logic [3:0][W-1:0] c_pp;
    logic              adv;

    logic              s1_v, s1_neg, s2_v, s2_neg;
    logic [W-1:0]      s1_mag_a, s1_mag_b;
    logic [3:0][W-1:0] s2_pp;

    mulhi_sign_prep #(.W(W)) u_prep (
        .mode (in_mode),
        .opa  (in_a),
        .opb  (in_b),
        .mag_a(c_mag_a),
        .mag_b(c_mag_b),
        .neg  (c_neg)
    );

    mulhi_part_mul #(.W(W)) u_pmul (
        .mag_a(s1_mag_a),
        .mag_b(s1_mag_b),
        .pp   (c_pp)
    );

    mulhi_combine #(.W(W)) u_comb (
        .pp    (s2_pp),
        .neg   (s2_neg),
        .result(c_result)
    );

    // Global advance: move when the output slot is free or taken.
    always_comb begin
        adv      = !out_valid || out_ready;
        in_ready = adv;
    end

    // Stage 1: capture operand magnitudes and sign.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v     <= 1'b0;
            s1_neg   <= 1'b0;
            s1_mag_a <= '0;
            s1_mag_b <= '0;
        end else if (adv) begin
            s1_v     <= in_valid;
            s1_neg   <= c_neg;
            s1_mag_a <= c_mag_a;
            s1_mag_b <= c_mag_b;
        end
    end

    // Stage 2: register the four partial products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v   <= 1'b0;
            s2_neg <= 1'b0;
            s2_pp  <= '0;
        end else if (adv) begin
            s2_v   <= s1_v;
            s2_neg <= s1_neg;
            s2_pp  <= c_pp;
        end
    end

    // Stage 3: register the signed upper half at the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (adv) begin
            out_valid <= s2_v;
            out_data  <= c_result;
        end
    end

    // R7: a held result stays put.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R7: a refused input leaves the capture stage untouched.
    a_r7_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_ready |=> $stable(s1_v) && $stable(s1_mag_a));

    // R6: a ready consumer lets the last internal stage reach the output.
    a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
        s2_v && out_ready |=> out_valid);

    // R9: a new result always comes from the stage before it.
    a_r9_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(s2_v));
endmodule

// File: tb/sim_mulhi_unit.sv
`timescale 1ns/1ps
module sim_mulhi_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready, out_valid, out_ready;
    logic [1:0]  in_mode;
    logic [63:0] in_a, in_b, out_data;

    int checks = 0;
    int errors = 0;

    // Behavioural pipeline model: three slots.
    bit          mv [3];
    logic [63:0] md [3];
    string       mt [3];

    always #4 clk = ~clk;

    mulhi_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [63:0] ref_hi(logic [1:0] m, logic [63:0] a, logic [63:0] b);
        logic [127:0] ea, eb, p;
        ea = (m == 2'b00 || m == 2'b01) ? {{64{a[63]}}, a} : {64'b0, a};
        eb = (m == 2'b00) ? {{64{b[63]}}, b} : {64'b0, b};
        p  = ea * eb;
        return p[127:64];
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One cycle: compare, drive, check ready, advance the model.
    task automatic step(bit iv, logic [1:0] m, logic [63:0] a, logic [63:0] b,
                        bit rdy, string tag);
        bit adv;
        @(negedge clk);
        check(out_valid == mv[2], mv[2] ? "R6/R9 valid" : "R9 idle",
              64'(out_valid), 64'(mv[2]));
        if (mv[2]) check(out_data == md[2], mt[2], out_data, md[2]);
        in_valid  = iv;
        in_mode   = m;
        in_a      = a;
        in_b      = b;
        out_ready = rdy;
        #1;
        adv = !mv[2] || rdy;
        check(in_ready == adv, "R7 ready", 64'(in_ready), 64'(adv));
        if (adv) begin
            mv[2] = mv[1]; md[2] = md[1]; mt[2] = mt[1];
            mv[1] = mv[0]; md[1] = md[0]; mt[1] = mt[0];
            mv[0] = iv;    md[0] = ref_hi(m, a, b); mt[0] = tag;
        end
    endtask

    function automatic string mode_tag(logic [1:0] m);
        return (m == 2'b00) ? "R1" : (m == 2'b01) ? "R2" : "R3";
    endfunction

    initial begin
        #(100000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] mn;
        mn = 64'h8000_0000_0000_0000;
        for (int i = 0; i < 3; i++) begin mv[i] = 0; md[i] = '0; mt[i] = ""; end
        rst_n = 1'b0; in_valid = 0; out_ready = 0; in_mode = 0; in_a = 0; in_b = 0;
        repeat (3) @(negedge clk);
        // R8: reset state.
        check(out_valid == 1'b0, "R8 out_valid", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R8 in_ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;

        // R6: single operation, free-flowing output.
        step(1, 2'b10, 64'd7, 64'd9, 1, "R3 small");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, "");

        // R4: most negative operands.
        step(1, 2'b00, mn, mn, 1, "R4 ss min*min");
        step(1, 2'b00, mn, '1, 1, "R4 ss min*-1");
        step(1, 2'b00, mn, 64'd1, 1, "R4 ss min*1");
        step(1, 2'b01, mn, mn, 1, "R4 su min*2^63");
        step(1, 2'b10, '1, '1, 1, "R3 uu max*max");
        step(1, 2'b11, '1, '1, 1, "R3 mode3 max*max");
        // R5: negation increment only when low half is zero.
        step(1, 2'b00, '1, 64'd1, 1, "R5 -1*1");
        step(1, 2'b00, 64'hFFFF_FFFF_0000_0000, 64'h1_0000_0000, 1, "R5 -2^32*2^32");
        step(1, 2'b01, 64'hFFFF_FFFF_FFFF_FFFE, 64'h8000_0000_0000_0000, 1, "R5 su -2*2^63");
        step(1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFD, 64'd5, 1, "R5 -3*5");
        step(1, 2'b01, 64'd3, '1, 1, "R2 3*max");
        // R7: stall with a full pipeline and a waiting input.
        for (int i = 0; i < 5; i++)
            step(1, 2'b00, 64'h1234_5678_9ABC_DEF0, 64'hFEDC_BA98_7654_3210, 0, "R7 stalled R1");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, "");

        // Random traffic with random back-pressure, all mode codes.
        for (int i = 0; i < 4000; i++) begin
            logic [1:0]  m;
            logic [63:0] a, b;
            m = 2'($urandom);
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if ($urandom % 8 == 0) a = mn;
            if ($urandom % 8 == 0) b = {32'h0, $urandom} << 32;
            step(($urandom % 4) != 0, m, a, b, ($urandom % 3) != 0, mode_tag(m));
        end
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, "");
        finish_run();
    end
endmodule